// File: doc/BRIEF.md
# Controller Command and Interrupt Status Core

This block is the host-facing control core of a network controller. It keeps an 8-bit command register and an 8-bit interrupt status register. The command register carries a register-page selector, a three-bit remote-transfer command, a transmit request, a start bit and a stop bit. The status register gathers event pulses from the transfer, transmit, receive and statistics logic into sticky flags. The host clears those flags by writing ones to them.

An 8-bit interrupt mask selects which flags drive a single interrupt line. The host reaches all three registers through a simple address/data port with write and read strobes. Read data is registered.

The datapaths that produce the events lie outside this block, as do the other register pages.

Top module: `nic_ctrl_core`

## Requirements
- R1: After synchronous reset the command register reads 0x01 (stop set) and the status register reads 0x80 (bit 7 set). The mask reads 0x00, and page_sel, running, tx_req and irq are all 0.
- R2: A command write at address 0 stores the byte. On that clock edge, page_sel takes bits 7:6 and running becomes bit 1 AND NOT bit 0.
- R3: A command write with bit 0 = 1 sets status bit 7. A command write with bit 1 = 1 and bit 0 = 0 clears status bit 7. A host write to status bit 7 has no effect.
- R4: Command bit 2 (tx_req) is set by writing 1 and is not cleared by writing 0. It clears when any transmit completion pulse arrives (ok, collision or underrun). If a write of 1 and a completion arrive in the same cycle, the write wins.
- R5: A remote-transfer completion pulse sets status bit 6 and loads command bits 5:3 with 100, unless a command write happens in the same cycle.
- R6: Single-cause flags: status bit 5 is set by a tally-counter MSB pulse, bit 4 by ring-full, bit 1 by transmit-ok and bit 0 by receive-ok.
- R7: Status bit 3 is set by a collision-limit pulse or a transmit underrun pulse. Status bit 2 is set by any one of the CRC, alignment, receive overrun or missed-packet pulses.
- R8: Writing 1 to any of status bits 6:0 clears that bit, and writing 0 leaves it unchanged. If a set event arrives in the same cycle as a clear, the bit stays set.
- R9: irq is the OR over bits 6:0 of (status AND mask). It changes on the same edge as the status or mask change that causes it.
- R10: Address 0 maps the command register on every page. Address 7 maps status and address 15 maps the mask, but only while page_sel = 00. On any other page, reads at those addresses return 0 and writes are ignored, and unmapped addresses read 0. rdata updates on the edge that samples rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ev_dma_done | input | 1 | Remote transfer finished pulse |
| ev_tally_msb | input | 1 | A tally counter MSB became set |
| ev_ring_full | input | 1 | Receive ring out of space |
| ev_tx_ok | input | 1 | Transmit finished without error |
| ev_tx_collide | input | 1 | Transmit aborted, collision limit |
| ev_tx_underrun | input | 1 | Transmit FIFO underrun |
| ev_rx_ok | input | 1 | Receive finished without error |
| ev_rx_crc | input | 1 | Received frame CRC error |
| ev_rx_align | input | 1 | Received frame alignment error |
| ev_rx_overrun | input | 1 | Receive FIFO overrun |
| ev_rx_missed | input | 1 | Frame missed |
| page_sel | output | 2 | Current register page |
| running | output | 1 | Controller is started |
| tx_req | output | 1 | Transmit request pending |
| irq | output | 1 | Masked interrupt |

## Verification
Every register, along with page_sel, running, tx_req and irq, takes its new value on the same edge that samples the write strobe or the event pulse. Registered read data appears on the edge that samples rd_en. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It samples outputs at that second falling edge, so every result is read half a cycle after the single edge that produced it. Readbacks use a separate read cycle after the write cycle.

// File: rtl/nic_ctrl_pkg.sv
package nic_ctrl_pkg;
  localparam int REG_W  = 8;
  localparam int NUM_EV = 7;

  localparam int CMD_STOP  = 0;
  localparam int CMD_START = 1;
  localparam int CMD_TX    = 2;
  localparam int CMD_RD_LO = 3;
  localparam int CMD_RD_HI = 5;
  localparam int CMD_PG_LO = 6;
  localparam int CMD_PG_HI = 7;

  localparam int ST_RX_OK  = 0;
  localparam int ST_TX_OK  = 1;
  localparam int ST_RX_ERR = 2;
  localparam int ST_TX_ERR = 3;
  localparam int ST_RING   = 4;
  localparam int ST_TALLY  = 5;
  localparam int ST_DMA    = 6;
  localparam int ST_RESET  = 7;

  localparam logic [REG_W-1:0] CMD_RST_VAL  = 8'h01;
  localparam logic [REG_W-1:0] STAT_RST_VAL = 8'h80;
  localparam logic [CMD_RD_HI-CMD_RD_LO:0] RD_DONE = 3'b100;

  typedef struct packed {
    logic dma_done;
    logic tally_msb;
    logic ring_full;
    logic tx_ok;
    logic tx_collide;
    logic tx_underrun;
    logic rx_ok;
    logic rx_crc;
    logic rx_align;
    logic rx_overrun;
    logic rx_missed;
  } nic_evt_t;
endpackage

// File: rtl/nic_event_map.sv
module nic_event_map
  import nic_ctrl_pkg::*;
(
  input  nic_evt_t          evt,
  output logic [NUM_EV-1:0] set_vec,
  output logic              tx_done
);
  always_comb begin
    set_vec            = '0;
    set_vec[ST_RX_OK]  = evt.rx_ok;
    set_vec[ST_TX_OK]  = evt.tx_ok;
    set_vec[ST_RX_ERR] = evt.rx_crc | evt.rx_align | evt.rx_overrun | evt.rx_missed;
    set_vec[ST_TX_ERR] = evt.tx_collide | evt.tx_underrun;
    set_vec[ST_RING]   = evt.ring_full;
    set_vec[ST_TALLY]  = evt.tally_msb;
    set_vec[ST_DMA]    = evt.dma_done;
    tx_done            = evt.tx_ok | evt.tx_collide | evt.tx_underrun;
  end
endmodule

// File: rtl/nic_cmd_reg.sv
module nic_cmd_reg
  import nic_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_done,
  input  logic             dma_done,
  output logic [REG_W-1:0] cmd_q,
  output logic             run_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_RST_VAL;
      run_q <= 1'b0;
    end else begin
      if (wr) begin
        cmd_q[CMD_PG_HI:CMD_PG_LO] <= wdata[CMD_PG_HI:CMD_PG_LO];
        cmd_q[CMD_RD_HI:CMD_RD_LO] <= wdata[CMD_RD_HI:CMD_RD_LO];
        cmd_q[CMD_START]           <= wdata[CMD_START];
        cmd_q[CMD_STOP]            <= wdata[CMD_STOP];
        run_q                      <= wdata[CMD_START] & ~wdata[CMD_STOP];
      end else if (dma_done) begin
        cmd_q[CMD_RD_HI:CMD_RD_LO] <= RD_DONE;
      end
      if (wr && wdata[CMD_TX]) begin
        cmd_q[CMD_TX] <= 1'b1;
      end else if (tx_done) begin
        cmd_q[CMD_TX] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nic_status_reg.sv
module nic_status_reg
  import nic_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] set_vec,
  input  logic [NUM_EV-1:0] clr_vec,
  input  logic              stop_set,
  input  logic              start_clr,
  input  logic              mask_wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  stat_q,
  output logic [REG_W-1:0]  mask_q,
  output logic              irq_q
);
  logic [REG_W-1:0] stat_d;
  logic [REG_W-1:0] mask_d;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    assign stat_d[i] = set_vec[i] | (stat_q[i] & ~clr_vec[i]);
  end
  assign stat_d[ST_RESET] = stop_set | (stat_q[ST_RESET] & ~start_clr);
  assign mask_d = mask_wr ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_RST_VAL;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_d[NUM_EV-1:0] & mask_d[NUM_EV-1:0]);
    end
  end
endmodule

// File: rtl/nic_reg_read.sv
module nic_reg_read
  import nic_ctrl_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(7),
  parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(15)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              page0,
  input  logic [REG_W-1:0]  cmd_q,
  input  logic [REG_W-1:0]  stat_q,
  input  logic [REG_W-1:0]  mask_q,
  output logic [REG_W-1:0]  rdata_q
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == CMD_ADDR)                sel = cmd_q;
    else if (page0 && addr == STAT_ADDR) sel = stat_q;
    else if (page0 && addr == MASK_ADDR) sel = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel;
  end
endmodule

// File: rtl/nic_ctrl_core.sv
module nic_ctrl_core
  import nic_ctrl_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(7),
  parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(15)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              ev_dma_done,
  input  logic              ev_tally_msb,
  input  logic              ev_ring_full,
  input  logic              ev_tx_ok,
  input  logic              ev_tx_collide,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_ok,
  input  logic              ev_rx_crc,
  input  logic              ev_rx_align,
  input  logic              ev_rx_overrun,
  input  logic              ev_rx_missed,
  output logic [1:0]        page_sel,
  output logic              running,
  output logic              tx_req,
  output logic              irq
);
  nic_evt_t          evt;
  logic [NUM_EV-1:0] set_vec;
  logic [NUM_EV-1:0] clr_vec;
  logic              tx_done;
  logic [REG_W-1:0]  cmd_q;
  logic [REG_W-1:0]  stat_q;
  logic [REG_W-1:0]  mask_q;
  logic              run_q;
  logic              irq_q;
  logic              page0;
  logic              cmd_wr;
  logic              stat_wr;
  logic              mask_wr;
  logic              stop_set;
  logic              start_clr;

  assign evt = '{dma_done: ev_dma_done, tally_msb: ev_tally_msb, ring_full: ev_ring_full,
                 tx_ok: ev_tx_ok, tx_collide: ev_tx_collide, tx_underrun: ev_tx_underrun,
                 rx_ok: ev_rx_ok, rx_crc: ev_rx_crc, rx_align: ev_rx_align,
                 rx_overrun: ev_rx_overrun, rx_missed: ev_rx_missed};

  assign page0     = (cmd_q[CMD_PG_HI:CMD_PG_LO] == 2'b00);
  assign cmd_wr    = wr_en && (addr == CMD_ADDR);
  assign stat_wr   = wr_en && page0 && (addr == STAT_ADDR);
  assign mask_wr   = wr_en && page0 && (addr == MASK_ADDR);
  assign stop_set  = cmd_wr && wdata[CMD_STOP];
  assign start_clr = cmd_wr && wdata[CMD_START] && !wdata[CMD_STOP];
  assign clr_vec   = stat_wr ? wdata[NUM_EV-1:0] : '0;

  nic_event_map u_evmap (
    .evt     (evt),
    .set_vec (set_vec),
    .tx_done (tx_done)
  );

  nic_cmd_reg u_cmd (
    .clk      (clk),
    .rst      (rst),
    .wr       (cmd_wr),
    .wdata    (wdata),
    .tx_done  (tx_done),
    .dma_done (ev_dma_done),
    .cmd_q    (cmd_q),
    .run_q    (run_q)
  );

  nic_status_reg u_stat (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .stop_set  (stop_set),
    .start_clr (start_clr),
    .mask_wr   (mask_wr),
    .wdata     (wdata),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq_q     (irq_q)
  );

  nic_reg_read #(
    .ADDR_W    (ADDR_W),
    .CMD_ADDR  (CMD_ADDR),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd      (rd_en),
    .addr    (addr),
    .page0   (page0),
    .cmd_q   (cmd_q),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .rdata_q (rdata)
  );

  assign page_sel = cmd_q[CMD_PG_HI:CMD_PG_LO];
  assign running  = run_q;
  assign tx_req   = cmd_q[CMD_TX];
  assign irq      = irq_q;
endmodule

// File: rtl/nic_ctrl_core_chk.sv
module nic_ctrl_core_chk #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(7),
  parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(15)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              ev_tx_ok,
  input logic              ev_tx_collide,
  input logic              ev_tx_underrun,
  input logic              ev_rx_ok,
  input logic              ev_rx_crc,
  input logic              ev_rx_align,
  input logic              ev_rx_overrun,
  input logic              ev_rx_missed,
  input logic [1:0]        page_sel,
  input logic              running,
  input logic              tx_req,
  input logic              irq,
  input logic [7:0]        stat_q,
  input logic [7:0]        mask_q
);
  logic cmd_w;
  logic stat_w;
  logic tx_end;
  logic rx_bad;
  assign cmd_w  = wr_en && addr == CMD_ADDR;
  assign stat_w = wr_en && addr == STAT_ADDR && page_sel == 2'b00;
  assign tx_end = ev_tx_ok | ev_tx_collide | ev_tx_underrun;
  assign rx_bad = ev_rx_crc | ev_rx_align | ev_rx_overrun | ev_rx_missed;

  // R2
  stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && wdata[0]) |=> !running);

  // R3
  start_clears_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && wdata[1] && !wdata[0]) |=> (!stat_q[7] && running));

  // R3
  rst_bit_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == STAT_ADDR) |=> (stat_q[7] == $past(stat_q[7])));

  // R4
  tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_end && !(cmd_w && wdata[2])) |=> !tx_req);

  // R7
  rx_err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rx_bad |=> stat_q[2]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_rx_ok |=> stat_q[0]);

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_w && wdata[0] && !ev_rx_ok) |=> !stat_q[0]);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_ok && mask_q[0] && !(wr_en && addr == MASK_ADDR)) |=> irq);
endmodule

bind nic_ctrl_core nic_ctrl_core_chk #(
  .ADDR_W    (ADDR_W),
  .CMD_ADDR  (CMD_ADDR),
  .STAT_ADDR (STAT_ADDR),
  .MASK_ADDR (MASK_ADDR)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_en          (wr_en),
  .addr           (addr),
  .wdata          (wdata),
  .ev_tx_ok       (ev_tx_ok),
  .ev_tx_collide  (ev_tx_collide),
  .ev_tx_underrun (ev_tx_underrun),
  .ev_rx_ok       (ev_rx_ok),
  .ev_rx_crc      (ev_rx_crc),
  .ev_rx_align    (ev_rx_align),
  .ev_rx_overrun  (ev_rx_overrun),
  .ev_rx_missed   (ev_rx_missed),
  .page_sel       (page_sel),
  .running        (running),
  .tx_req         (tx_req),
  .irq            (irq),
  .stat_q         (stat_q),
  .mask_q         (mask_q)
);

// File: tb/nic_ctrl_core_tb.sv
`timescale 1ns/1ps
module nic_ctrl_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [10:0] ev = '0;
  logic [1:0]  page_sel;
  logic        running;
  logic        tx_req;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  // event bits: 0 dma,1 tally,2 ring,3 tx_ok,4 collide,5 underrun,6 rx_ok,7 crc,8 align,9 overrun,10 missed
  always #2.5 clk = ~clk;

  nic_ctrl_core u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ev_dma_done(ev[0]), .ev_tally_msb(ev[1]), .ev_ring_full(ev[2]), .ev_tx_ok(ev[3]),
    .ev_tx_collide(ev[4]), .ev_tx_underrun(ev[5]), .ev_rx_ok(ev[6]), .ev_rx_crc(ev[7]),
    .ev_rx_align(ev[8]), .ev_rx_overrun(ev[9]), .ev_rx_missed(ev[10]),
    .page_sel(page_sel), .running(running), .tx_req(tx_req), .irq(irq)
  );

  // {op(1 write, 2 read-check), addr, data, requirement}
  localparam int NV = 23;
  localparam logic [17:0] VEC [NV] = '{
    {2'd2, 4'h0, 8'h01, 4'd1},   // R1 command reset value
    {2'd2, 4'h7, 8'h80, 4'd1},   // R1 status reset value
    {2'd2, 4'hF, 8'h00, 4'd1},   // R1 mask reset value
    {2'd1, 4'h0, 8'h22, 4'd2},   // R2 start
    {2'd2, 4'h0, 8'h22, 4'd2},
    {2'd2, 4'h7, 8'h00, 4'd3},   // R3 start cleared bit 7
    {2'd1, 4'h7, 8'h80, 4'd3},
    {2'd2, 4'h7, 8'h00, 4'd3},   // R3 host write to bit 7 ignored
    {2'd1, 4'hF, 8'h7F, 4'd9},
    {2'd2, 4'hF, 8'h7F, 4'd9},
    {2'd1, 4'h0, 8'h62, 4'd10},  // R10 page 1
    {2'd2, 4'h7, 8'h00, 4'd10},
    {2'd2, 4'hF, 8'h00, 4'd10},
    {2'd1, 4'hF, 8'h00, 4'd10},
    {2'd1, 4'h0, 8'h22, 4'd10},
    {2'd2, 4'hF, 8'h7F, 4'd10},  // R10 page-1 write was ignored
    {2'd2, 4'h3, 8'h00, 4'd10},  // R10 unmapped
    {2'd1, 4'h0, 8'h21, 4'd3},   // R3 stop
    {2'd2, 4'h7, 8'h80, 4'd3},
    {2'd1, 4'h7, 8'hFF, 4'd3},
    {2'd2, 4'h7, 8'h80, 4'd3},
    {2'd1, 4'h0, 8'h22, 4'd3},
    {2'd2, 4'h7, 8'h00, 4'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [3:0] a, input logic [7:0] d, input logic [10:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ev = e;
    @(negedge clk);
    wr_en = 1'b0; ev = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    drive(1'b1, a, d, '0);
  endtask

  task automatic pulse(input int b);
    drive(1'b0, 4'h0, 8'h00, 11'(1) << b);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 page_sel", page_sel, 0);
    check("R1 running", running, 0);
    check("R1 tx_req", tx_req, 0);
    check("R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17:16] == 2'd1) wr(VEC[i][15:12], VEC[i][11:4]);
      else begin
        rd(VEC[i][15:12], v);
        check($sformatf("R%0d table step %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
      end
    end

    check("R2 running", running, 1);
    check("R2 page_sel", page_sel, 0);
    check("R9 irq idle", irq, 0);

    wr(4'h0, 8'h26);
    check("R4 tx_req set", tx_req, 1);
    wr(4'h0, 8'h22);
    check("R4 write 0 keeps tx_req", tx_req, 1);
    pulse(3);
    check("R4 tx_ok clears", tx_req, 0);
    check("R9 irq on tx_ok", irq, 1);
    rd(4'h7, v); check("R6 tx_ok flag", v, 8'h02);
    wr(4'h7, 8'h02);
    check("R9 irq drops", irq, 0);

    for (int b = 4; b <= 5; b++) begin
      wr(4'h0, 8'h26);
      pulse(b);
      check("R4 tx error clears tx_req", tx_req, 0);
      rd(4'h7, v); check("R7 tx error flag", v, 8'h08);
      wr(4'h7, 8'hFF);
    end
    for (int b = 7; b <= 10; b++) begin
      pulse(b);
      rd(4'h7, v); check("R7 rx error flag", v, 8'h04);
      wr(4'h7, 8'hFF);
    end
    pulse(1); rd(4'h7, v); check("R6 tally flag", v, 8'h20); wr(4'h7, 8'hFF);
    pulse(2); rd(4'h7, v); check("R6 ring flag", v, 8'h10); wr(4'h7, 8'hFF);
    pulse(6); rd(4'h7, v); check("R6 rx_ok flag", v, 8'h01); wr(4'h7, 8'hFF);

    wr(4'h0, 8'h0A);
    pulse(0);
    rd(4'h0, v); check("R5 command field done", v, 8'h22);
    rd(4'h7, v); check("R5 dma flag", v, 8'h40);

    pulse(6);
    rd(4'h7, v); check("R8 two flags", v, 8'h41);
    wr(4'h7, 8'h01);
    rd(4'h7, v); check("R8 write-1 clears one", v, 8'h40);
    wr(4'h7, 8'h00);
    rd(4'h7, v); check("R8 write-0 no change", v, 8'h40);
    drive(1'b1, 4'h7, 8'h40, 11'h001);
    rd(4'h7, v); check("R8 set wins", v, 8'h40);
    wr(4'h7, 8'h40);
    rd(4'h7, v); check("R8 cleared", v, 8'h00);

    wr(4'hF, 8'h01);
    pulse(0);
    check("R9 masked flag no irq", irq, 0);
    pulse(6);
    check("R9 unmasked flag irq", irq, 1);
    wr(4'hF, 8'h00);
    check("R9 mask removal drops irq", irq, 0);
    wr(4'h7, 8'hFF);

    drive(1'b1, 4'h0, 8'h26, 11'h008);
    check("R4 write wins over completion", tx_req, 1);
    pulse(3);
    check("R4 cleared after", tx_req, 0);

    wr(4'h0, 8'h62);
    check("R2 page_sel", page_sel, 1);
    wr(4'h0, 8'h61);
    check("R2 stop halts", running, 0);

    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(4'h0, v); check("R1 command after reset", v, 8'h01);
    rd(4'h7, v); check("R1 status after reset", v, 8'h80);
    check("R1 outputs after reset", {page_sel, running, tx_req, irq}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule